// File: doc/BRIEF.md
# Programmable Fault-Input Glitch Filter

This block qualifies one asynchronous fault line from the power stage before the driver controller acts on it. The raw line first passes through a two-flop synchronizer. A qualifier then accepts a new level only after that level has held steady for a programmed number of 100 MHz clock ticks. Short spikes are discarded in both directions: a brief assertion does not raise the fault, and a brief drop does not clear it. The programmed width is a 7-bit tick count. The two synchronizer ticks add a fixed offset, so the shortest pulse that gets through lasts `width * 10 ns + 20 ns`.

Two control inputs choose the mode. The filter runs only when the elimination enable is 1 and the bypass bit is 0. In every other combination the output follows the synchronized input with no added delay, and the qualifying counter is held at zero. The threshold is captured while the input agrees with the output. A change to the width field therefore applies from the next input transition, not partway through a count. The register decode that supplies the width field, with its reset value of 1, sits outside this block.

Top module: `fault_deglitch`

## Requirements
- R1: While reset is asserted and after it is released with the raw input low, `fault_o` is 0.
- R2: The raw input is sampled by two flops in series. When filtering is inactive, a raw change first sampled on rising edge k appears on `fault_o` right after edge k+1, and a pulse of any length, including one cycle, keeps its length.
- R3: Filtering is active only when `elim_en_i` is 1 and `bypass_i` is 0. The other three combinations behave as described in R2.
- R4: With filtering active, a new raw level reaches `fault_o` only if it is held for at least `width_i + 2` consecutive clock cycles. A shorter excursion leaves `fault_o` unchanged.
- R5: With filtering active, an accepted level first sampled on edge k appears on `fault_o` right after edge k + `width_i` + 3. An accepted pulse keeps its exact length at the output.
- R6: With `width_i` = 0, a 2-cycle pulse passes and a 1-cycle pulse is rejected (a 20 ns minimum).
- R7: With `width_i` = 127, a 129-cycle pulse passes and a 128-cycle pulse is rejected.
- R8: A change to `width_i` while a new level is being qualified does not alter that qualification. The new value applies from the next transition.
- R9: Filtering is symmetric. A low-going glitch while `fault_o` is high is rejected or accepted by the same rule as a high-going one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 100 MHz system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fault_raw_i | input | 1 | Unsynchronized fault line from the power stage |
| width_i | input | 7 | Minimum steady time in ticks, excluding the fixed 2-tick offset |
| bypass_i | input | 1 | 1 sends the synchronized input straight to the output |
| elim_en_i | input | 1 | 1 allows the filter to run (subject to bypass_i = 0) |
| fault_o | output | 1 | Qualified fault level |

## Verification
The hardest case to reach from the ports is a pulse exactly one cycle shorter than the threshold: the counter stops at its limit and never fires. The same holds when the width changes in the middle of a count, because the captured threshold is not visible at the ports. The bench sweeps every pulse length from 1 to width+3 for small widths, in both polarities, and tests both sides of the boundary at the largest width. It changes `width_i` a few cycles into a long pulse and checks the output edge against the old threshold. It then sends a 2-cycle pulse to show that the new value applies at the next transition.

// File: rtl/dgl_pkg.sv
package dgl_pkg;
    // Default field width of the programmed tick count
    localparam int unsigned DGL_WIDTH_BITS = 7;
    // Synchronizer depth; also the fixed tick offset of the minimum pulse
    localparam int unsigned DGL_SYNC_STAGES = 2;
    // Value captured as the threshold source while in reset
    localparam int unsigned DGL_RST_WIDTH = 1;

    // Number of consecutive disagreeing samples required before a level flips
    function automatic int unsigned dgl_samples(input int unsigned width);
        return width + 2;
    endfunction
endpackage

// File: rtl/dgl_sync.sv
module dgl_sync #(
    parameter int unsigned STAGES = dgl_pkg::DGL_SYNC_STAGES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.chain[0] = async_i;
        for (int i = 1; i < int'(STAGES); i++) begin
            st_d.chain[i] = st_q.chain[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_o = st_q.chain[STAGES-1];
endmodule

// File: rtl/dgl_qual.sv
module dgl_qual #(
    parameter int unsigned WIDTH_BITS = dgl_pkg::DGL_WIDTH_BITS,
    parameter int unsigned RST_WIDTH  = dgl_pkg::DGL_RST_WIDTH
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  act_i,
    input  logic                  lvl_i,
    input  logic [WIDTH_BITS-1:0] width_i,
    output logic                  out_o
);
    // One extra bit: the limit is width + 1
    localparam int unsigned CNT_BITS = WIDTH_BITS + 1;
    localparam logic [CNT_BITS-1:0] THR_RST = CNT_BITS'(RST_WIDTH + 1);

    typedef struct packed {
        logic [CNT_BITS-1:0] cnt;
        logic [CNT_BITS-1:0] thr;
        logic                out;
    } qual_state_t;

    qual_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!act_i) begin
            // Track the synchronized level so re-enabling starts clean
            st_d.cnt = '0;
            st_d.out = lvl_i;
            st_d.thr = {1'b0, width_i} + CNT_BITS'(1);
        end else if (lvl_i == st_q.out) begin
            // Agreement: restart counting and capture the threshold
            st_d.cnt = '0;
            st_d.thr = {1'b0, width_i} + CNT_BITS'(1);
        end else if (st_q.cnt == st_q.thr) begin
            st_d.cnt = '0;
            st_d.out = lvl_i;
        end else begin
            st_d.cnt = st_q.cnt + CNT_BITS'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt <= '0;
            st_q.thr <= THR_RST;
            st_q.out <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_o = st_q.out;

    assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= st_q.thr);

    assert_flip_at_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (act_i && $past(act_i) && st_q.out != $past(st_q.out))
            |-> ($past(st_q.cnt) == $past(st_q.thr)));

    assert_thr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (act_i && lvl_i != st_q.out) |=> (st_q.thr == $past(st_q.thr)));

    assert_idle_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!act_i) |=> (st_q.cnt == '0));
endmodule

// File: rtl/fault_deglitch.sv
module fault_deglitch #(
    parameter int unsigned WIDTH_BITS  = dgl_pkg::DGL_WIDTH_BITS,
    parameter int unsigned SYNC_STAGES = dgl_pkg::DGL_SYNC_STAGES,
    parameter int unsigned RST_WIDTH   = dgl_pkg::DGL_RST_WIDTH
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  fault_raw_i,
    input  logic [WIDTH_BITS-1:0] width_i,
    input  logic                  bypass_i,
    input  logic                  elim_en_i,
    output logic                  fault_o
);
    logic lvl_sync;
    logic filt_out;
    logic active;

    assign active = elim_en_i & ~bypass_i;

    dgl_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (fault_raw_i),
        .sync_o  (lvl_sync)
    );

    dgl_qual #(.WIDTH_BITS(WIDTH_BITS), .RST_WIDTH(RST_WIDTH)) u_qual (
        .clk     (clk),
        .rst_n   (rst_n),
        .act_i   (active),
        .lvl_i   (lvl_sync),
        .width_i (width_i),
        .out_o   (filt_out)
    );

    assign fault_o = active ? filt_out : lvl_sync;

    assert_reset_low_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> !fault_o);

    assert_bypass_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && $past(!active) && $past(rst_n, 2))
            |-> (fault_o == $past(fault_raw_i, 2)));
endmodule

// File: tb/tb_fault_deglitch.sv
module tb_fault_deglitch;
    localparam time CLK_PERIOD = 10ns;
    localparam int  WB = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          raw = 1'b0;
    logic [WB-1:0] width = 7'd1;
    logic          bypass = 1'b0;
    logic          elim = 1'b1;
    logic          fault;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    fault_deglitch dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .fault_raw_i (raw),
        .width_i     (width),
        .bypass_i    (bypass),
        .elim_en_i   (elim),
        .fault_o     (fault)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic act, input logic exp, input int t);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s t=%0d actual=%0b expected=%0b", req, t, act, exp);
        end
    endtask

    task automatic settle(input logic b, input int cyc);
        @(posedge clk); #1 raw = b;
        repeat (cyc) @(posedge clk);
        @(negedge clk);
    endtask

    // Filtered pulse of n cycles opposite to base level b, expected arithmetically
    task automatic filt_pulse(input string req, input int w, input int n, input logic b);
        bit pass;
        width = WB'(w);
        settle(b, w + 8);
        check(req, fault, b, -1);
        pass = (n >= w + 2);
        for (int t = 0; t < n + w + 7; t++) begin
            @(posedge clk); #1 raw = (t < n) ? ~b : b;
            @(negedge clk);
            check(req, fault, b ^ (pass && t >= w + 4 && t < n + w + 4), t);
        end
    endtask

    task automatic pass_pulse(input string req, input int n, input logic b);
        settle(b, 6);
        check(req, fault, b, -1);
        for (int t = 0; t < n + 5; t++) begin
            @(posedge clk); #1 raw = (t < n) ? ~b : b;
            @(negedge clk);
            check(req, fault, b ^ (t >= 2 && t < n + 2), t);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1", fault, 1'b0, -1);
        @(posedge clk); #1 rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R1", fault, 1'b0, -1);

        // R4 R5 R9: sweep small widths, every length around threshold, both polarities
        for (int w = 0; w <= 6; w++) begin
            for (int n = 1; n <= w + 3; n++) begin
                filt_pulse("R4_R5", w, n, 1'b0);
                filt_pulse("R9", w, n, 1'b1);
            end
        end

        // R6: width zero boundaries
        filt_pulse("R6", 0, 1, 1'b0);
        filt_pulse("R6", 0, 2, 1'b0);

        // R7: largest width boundaries
        filt_pulse("R7", 127, 128, 1'b0);
        filt_pulse("R7", 127, 129, 1'b0);
        filt_pulse("R7", 127, 129, 1'b1);

        // R8: width change in mid-count keeps old threshold (5)
        width = 7'd5;
        settle(1'b0, 14);
        for (int t = 0; t < 30; t++) begin
            @(posedge clk); #1 raw = (t < 20);
            if (t == 3) width = 7'd0;
            @(negedge clk);
            check("R8", fault, (t >= 9 && t < 20 + 4), t);
        end
        // R8: new width applies from the next transition
        filt_pulse("R8", 0, 2, 1'b0);

        // R2 R3: bypass and filter-off combinations pass everything after two flops
        bypass = 1'b1; elim = 1'b1;
        for (int n = 1; n <= 4; n++) begin
            pass_pulse("R2_R3", n, 1'b0);
            pass_pulse("R2_R3", n, 1'b1);
        end
        bypass = 1'b0; elim = 1'b0;
        pass_pulse("R3", 1, 1'b0);
        bypass = 1'b1; elim = 1'b0;
        pass_pulse("R3", 1, 1'b0);

        // R3: re-enabled filter rejects short pulse again
        bypass = 1'b0; elim = 1'b1;
        filt_pulse("R3", 3, 4, 1'b0);
        filt_pulse("R3", 3, 5, 1'b0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule